// File: doc/BRIEF.md
# DMA channel control sequencer

This block is the per-channel control and status logic of a multi-channel DMA engine. It holds the channel's 32-bit control word, accepts start requests from software trigger writes and from chain events raised by other channels, and tracks whether a transfer sequence is in progress. Address generation and data movement sit outside the block. The block receives a "last transfer finished" strobe and read and write bus-error strobes from the transfer engine. In return it tells the engine whether transfers may be issued.

When a sequence finishes, the channel can start another channel through a one-hot chain output. It raises its interrupt either at the end of every block or, in quiet mode, only when software writes a zero value to a trigger register. A zero trigger write marks the end of a chain of control blocks. Clearing the enable bit pauses a running sequence rather than cancelling it. A bus error stops the channel until software clears the error flag. An abort input drops the sequence at once.

Top module: `dma_chan_ctrl`

## Requirements
- R1: After synchronous reset the control readback is 0x0000_3000, so the chain target field (bits 14:11) equals the channel's own number 6. busy, irq, halt, xfer_run and chain_out are all 0.
- R2: With enable (bit 0) set and no error halt, either a nonzero trigger write or an incoming chain trigger sets busy one cycle later. With enable clear, both are ignored.
- R3: While busy and running, a done strobe clears busy one cycle later. When quiet mode (bit 21) is clear, the same strobe produces a one-cycle irq pulse.
- R4: Clearing enable while busy keeps busy at 1 and drops xfer_run. A done strobe is ignored while paused. Setting enable again restores xfer_run without a new trigger.
- R5: A completion drives chain_out bit N high for exactly one cycle, where N is the chain target field at bits 14:11. A target equal to the channel's own number produces no pulse.
- R6: A trigger arriving while busy is already 1 is dropped and not queued. After the next completion busy stays 0.
- R7: Read error flag (bit 30) and write error flag (bit 29) are cleared by writing 1 to their bit. Writing 0 leaves them unchanged. Bit 31 reads as their OR, and writing bit 31 has no effect.
- R8: A read or write error strobe sets its flag and clears busy. It raises halt and a one-cycle irq one cycle later, even in quiet mode, and produces no chain pulse. Triggers are ignored while halt is 1.
- R9: In quiet mode a completion raises no irq, and a zero trigger write raises a one-cycle irq. A zero trigger write never starts a sequence, and outside quiet mode it has no effect.
- R10: An abort strobe clears busy one cycle later with no irq and no chain pulse. A later done strobe does nothing.
- R11: Bit 24 of the control readback reflects busy. Bits 28:25 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Control word write strobe |
| cfg_wdata | input | 32 | Control word write data |
| trig_wr | input | 1 | Trigger register write strobe |
| trig_val | input | 32 | Value written to the trigger register; zero is a null write |
| chain_in | input | 1 | Chain trigger addressed to this channel |
| xfer_done | input | 1 | Last transfer of the sequence finished |
| rd_err | input | 1 | Read bus error strobe |
| wr_err | input | 1 | Write bus error strobe |
| abort | input | 1 | Drop the current sequence |
| cfg_rdata | output | 32 | Control word readback with status bits |
| busy | output | 1 | Sequence in progress |
| xfer_run | output | 1 | Transfers may be issued (busy, enabled, not halted) |
| halt | output | 1 | Channel stopped by a bus error |
| irq | output | 1 | One-cycle channel interrupt pulse |
| chain_out | output | 16 | One-hot chain trigger to the target channel |

## Verification
Every result of the block is one register stage behind its cause. busy, irq, halt, chain_out and the readback status bits all change on the first clock edge after the stimulus is presented. xfer_run and the readback follow the same registers with no extra delay. The bench presents each stimulus at a falling edge and checks the outputs at the next falling edge. That check falls exactly one rising edge after the stimulus and before the next stimulus is driven. One-cycle pulses such as irq and chain_out are checked high in that cycle and low in the one after.

// File: rtl/dma_cc_pkg.sv
package dma_cc_pkg;
  localparam int CW_W       = 32;
  localparam int STORE_W    = 24;
  localparam int EN_BIT     = 0;
  localparam int QUIET_BIT  = 21;
  localparam int CHAIN_LSB  = 11;
  localparam int BUSY_BIT   = 24;
  localparam int WRERR_BIT  = 29;
  localparam int RDERR_BIT  = 30;
  localparam int ANYERR_BIT = 31;
endpackage

// File: rtl/dma_cc_ctrlreg.sv
module dma_cc_ctrlreg
  import dma_cc_pkg::*;
#(
  parameter int CH_ID  = 6,
  parameter int TGT_W  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_wr,
  input  logic [CW_W-1:0]  cfg_wdata,
  input  logic             rd_err,
  input  logic             wr_err,
  input  logic             busy,
  output logic [CW_W-1:0]  cfg_rdata,
  output logic             en,
  output logic             quiet,
  output logic [TGT_W-1:0] tgt,
  output logic             halt
);
  localparam logic [STORE_W-1:0] CW_RST = STORE_W'(CH_ID) << CHAIN_LSB;

  logic [STORE_W-1:0] cw_q;
  logic rd_f, wr_f, rd_n, wr_n;
  logic unused_wbits;

  assign unused_wbits = ^{cfg_wdata[ANYERR_BIT], cfg_wdata[WRERR_BIT-1:STORE_W]};

  // error flags: a set strobe wins over a simultaneous write-one clear
  assign rd_n = rd_err | (rd_f & ~(cfg_wr & cfg_wdata[RDERR_BIT]));
  assign wr_n = wr_err | (wr_f & ~(cfg_wr & cfg_wdata[WRERR_BIT]));

  always_ff @(posedge clk) begin
    if (rst) begin
      cw_q <= CW_RST;
      rd_f <= 1'b0;
      wr_f <= 1'b0;
      halt <= 1'b0;
    end else begin
      if (cfg_wr) cw_q <= cfg_wdata[STORE_W-1:0];
      rd_f <= rd_n;
      wr_f <= wr_n;
      halt <= rd_n | wr_n;
    end
  end

  assign cfg_rdata = {rd_f | wr_f, rd_f, wr_f, 4'b0000, busy, cw_q};
  assign en        = cw_q[EN_BIT];
  assign quiet     = cw_q[QUIET_BIT];
  assign tgt       = cw_q[CHAIN_LSB +: TGT_W];

  assert_w1c_clear_R7: assert property (@(posedge clk) disable iff (rst)
    (cfg_wr && cfg_wdata[RDERR_BIT] && !rd_err) |=> !cfg_rdata[RDERR_BIT]);
  assert_err_sets_halt_R8: assert property (@(posedge clk) disable iff (rst)
    (rd_err || wr_err) |=> halt && cfg_rdata[ANYERR_BIT]);
endmodule

// File: rtl/dma_cc_seq.sv
module dma_cc_seq #(
  parameter int CH_ID = 6,
  parameter int TGT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             quiet,
  input  logic             halt,
  input  logic [TGT_W-1:0] tgt,
  input  logic             trig_wr,
  input  logic             trig_null,
  input  logic             chain_in,
  input  logic             xfer_done,
  input  logic             err,
  input  logic             abort,
  output logic             busy,
  output logic             xfer_run,
  output logic             irq,
  output logic             fire
);
  logic start, done_ok, busy_n;

  assign xfer_run = busy & en & ~halt;
  assign start    = en & ~halt & ~busy & ((trig_wr & ~trig_null) | chain_in);
  assign done_ok  = xfer_run & xfer_done & ~err & ~abort;
  assign fire     = done_ok & (tgt != TGT_W'(CH_ID));

  always_comb begin
    busy_n = busy;
    if (err || abort)  busy_n = 1'b0;
    else if (done_ok)  busy_n = 1'b0;
    else if (start)    busy_n = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      irq  <= 1'b0;
    end else begin
      busy <= busy_n;
      irq  <= err | (done_ok & ~quiet) | (trig_wr & trig_null & quiet);
    end
  end

  assert_pause_holds_busy_R4: assert property (@(posedge clk) disable iff (rst)
    (busy && !en && !err && !abort) |=> busy);
  assert_err_irq_R8: assert property (@(posedge clk) disable iff (rst)
    (err) |=> (irq && !busy));
  assert_abort_clears_R10: assert property (@(posedge clk) disable iff (rst)
    (abort && !err) |=> (!busy && !irq));
  assert_no_start_when_off_R2: assert property (@(posedge clk) disable iff (rst)
    (!busy && !en) |=> !busy);
endmodule

// File: rtl/dma_cc_chain_dec.sv
module dma_cc_chain_dec #(
  parameter int CH_ID  = 6,
  parameter int TGT_W  = 4,
  parameter int NUM_CH = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fire,
  input  logic [TGT_W-1:0]  tgt,
  output logic [NUM_CH-1:0] chain_out
);
  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    always_ff @(posedge clk) begin
      if (rst) chain_out[i] <= 1'b0;
      else     chain_out[i] <= fire && (tgt == TGT_W'(i));
    end
  end

  assert_chain_onehot_R5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(chain_out));
  assert_no_self_chain_R5: assert property (@(posedge clk) disable iff (rst)
    !chain_out[CH_ID]);
endmodule

// File: rtl/dma_chan_ctrl.sv
module dma_chan_ctrl
  import dma_cc_pkg::*;
#(
  parameter int CH_ID   = 6,
  parameter int CHAIN_W = 4,
  localparam int NUM_CH = 1 << CHAIN_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic [31:0]       cfg_wdata,
  input  logic              trig_wr,
  input  logic [31:0]       trig_val,
  input  logic              chain_in,
  input  logic              xfer_done,
  input  logic              rd_err,
  input  logic              wr_err,
  input  logic              abort,
  output logic [31:0]       cfg_rdata,
  output logic              busy,
  output logic              xfer_run,
  output logic              halt,
  output logic              irq,
  output logic [NUM_CH-1:0] chain_out
);
  logic en, quiet, fire;
  logic [CHAIN_W-1:0] tgt;

  dma_cc_ctrlreg #(.CH_ID(CH_ID), .TGT_W(CHAIN_W)) u_reg (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .rd_err(rd_err), .wr_err(wr_err), .busy(busy), .cfg_rdata(cfg_rdata),
    .en(en), .quiet(quiet), .tgt(tgt), .halt(halt)
  );

  dma_cc_seq #(.CH_ID(CH_ID), .TGT_W(CHAIN_W)) u_seq (
    .clk(clk), .rst(rst), .en(en), .quiet(quiet), .halt(halt), .tgt(tgt),
    .trig_wr(trig_wr), .trig_null(trig_val == '0), .chain_in(chain_in),
    .xfer_done(xfer_done), .err(rd_err | wr_err), .abort(abort),
    .busy(busy), .xfer_run(xfer_run), .irq(irq), .fire(fire)
  );

  dma_cc_chain_dec #(.CH_ID(CH_ID), .TGT_W(CHAIN_W), .NUM_CH(NUM_CH)) u_dec (
    .clk(clk), .rst(rst), .fire(fire), .tgt(tgt), .chain_out(chain_out)
  );

  assert_busy_readback_R11: assert property (@(posedge clk) disable iff (rst)
    cfg_rdata[BUSY_BIT] == busy && cfg_rdata[28:25] == 4'b0000);
endmodule

// File: tb/dma_chan_ctrl_tb_top.sv
`timescale 1ns/1ps
module dma_chan_ctrl_tb_top;
  logic clk = 1'b0, rst = 1'b1;
  logic cfg_wr = 0, trig_wr = 0, chain_in = 0, xfer_done = 0;
  logic rd_err = 0, wr_err = 0, abort = 0;
  logic [31:0] cfg_wdata = '0, trig_val = '0;
  logic [31:0] cfg_rdata;
  logic busy, xfer_run, halt, irq;
  logic [15:0] chain_out;
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  dma_chan_ctrl dut_i (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .trig_wr(trig_wr), .trig_val(trig_val), .chain_in(chain_in),
    .xfer_done(xfer_done), .rd_err(rd_err), .wr_err(wr_err), .abort(abort),
    .cfg_rdata(cfg_rdata), .busy(busy), .xfer_run(xfer_run), .halt(halt),
    .irq(irq), .chain_out(chain_out)
  );

  typedef struct packed {
    bit [3:0]  rq;
    bit        wr;
    bit [31:0] wd;
    bit        tw;
    bit [31:0] tv;
    bit        ci, dn, re, we, ab;
    bit        eb, ei;
    bit [15:0] ec;
    bit        eh;
  } vec_t;

  localparam int NV = 32;
  // rq wr wd tw tv ci dn re we ab | busy irq chain halt
  localparam vec_t VT [NV] = '{
    '{4'd2, 1,32'h0000_1801,0,32'h0,0,0,0,0,0, 0,0,16'h0000,0}, // R2 enable, chain to 3
    '{4'd2, 0,32'h0,1,32'h10,0,0,0,0,0,     1,0,16'h0000,0}, // R2 trigger starts
    '{4'd6, 0,32'h0,1,32'h10,0,0,0,0,0,     1,0,16'h0000,0}, // R6 ignored while busy
    '{4'd5, 0,32'h0,0,32'h0,0,1,0,0,0,      0,1,16'h0008,0}, // R3 R5 completion
    '{4'd6, 0,32'h0,0,32'h0,0,0,0,0,0,      0,0,16'h0000,0}, // R6 R3 no requeue, pulse ends
    '{4'd2, 0,32'h0,0,32'h0,1,0,0,0,0,      1,0,16'h0000,0}, // R2 chain start
    '{4'd4, 1,32'h0000_1800,0,32'h0,0,0,0,0,0, 1,0,16'h0000,0}, // R4 pause
    '{4'd4, 0,32'h0,0,32'h0,0,1,0,0,0,      1,0,16'h0000,0}, // R4 done ignored paused
    '{4'd4, 1,32'h0000_1801,0,32'h0,0,0,0,0,0, 1,0,16'h0000,0}, // R4 resume
    '{4'd3, 0,32'h0,0,32'h0,0,1,0,0,0,      0,1,16'h0008,0}, // R3 done after resume
    '{4'd5, 1,32'h0000_3001,0,32'h0,0,0,0,0,0, 0,0,16'h0000,0}, // R5 self target
    '{4'd5, 0,32'h0,1,32'h5,0,0,0,0,0,      1,0,16'h0000,0},
    '{4'd5, 0,32'h0,0,32'h0,0,1,0,0,0,      0,1,16'h0000,0}, // R5 no chain pulse
    '{4'd9, 1,32'h0020_3001,0,32'h0,0,0,0,0,0, 0,0,16'h0000,0}, // R9 quiet on
    '{4'd9, 0,32'h0,1,32'h0,0,0,0,0,0,      0,1,16'h0000,0}, // R9 null write irq, no start
    '{4'd9, 0,32'h0,1,32'h7,0,0,0,0,0,      1,0,16'h0000,0},
    '{4'd9, 0,32'h0,0,32'h0,0,1,0,0,0,      0,0,16'h0000,0}, // R9 quiet completion no irq
    '{4'd9, 1,32'h0000_3001,0,32'h0,0,0,0,0,0, 0,0,16'h0000,0},
    '{4'd9, 0,32'h0,1,32'h0,0,0,0,0,0,      0,0,16'h0000,0}, // R9 null write, not quiet
    '{4'd2, 1,32'h0000_0000,0,32'h0,0,0,0,0,0, 0,0,16'h0000,0},
    '{4'd2, 0,32'h0,1,32'h9,1,0,0,0,0,      0,0,16'h0000,0}, // R2 disabled ignores
    '{4'd10,1,32'h0000_1801,0,32'h0,0,0,0,0,0, 0,0,16'h0000,0},
    '{4'd10,0,32'h0,1,32'h1,0,0,0,0,0,      1,0,16'h0000,0},
    '{4'd10,0,32'h0,0,32'h0,0,0,0,0,1,      0,0,16'h0000,0}, // R10 abort
    '{4'd10,0,32'h0,0,32'h0,0,1,0,0,0,      0,0,16'h0000,0}, // R10 stale done
    '{4'd8, 0,32'h0,1,32'h1,0,0,0,0,0,      1,0,16'h0000,0},
    '{4'd8, 0,32'h0,0,32'h0,0,0,1,0,0,      0,1,16'h0000,1}, // R8 read error
    '{4'd8, 0,32'h0,1,32'h1,0,0,0,0,0,      0,0,16'h0000,1}, // R8 halted ignores trigger
    '{4'd7, 1,32'h4000_1801,0,32'h0,0,0,0,0,0, 0,0,16'h0000,0}, // R7 W1C read flag
    '{4'd8, 1,32'h0020_1801,0,32'h0,0,0,0,0,0, 0,0,16'h0000,0},
    '{4'd8, 0,32'h0,0,32'h0,0,0,0,1,0,      0,1,16'h0000,1}, // R8 irq despite quiet
    '{4'd7, 1,32'h2020_1801,0,32'h0,0,0,0,0,0, 0,0,16'h0000,0}  // R7 W1C write flag
  };

  task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic idle_in();
    cfg_wr = 0; trig_wr = 0; chain_in = 0; xfer_done = 0;
    rd_err = 0; wr_err = 0; abort = 0; cfg_wdata = '0; trig_val = '0;
  endtask

  task automatic cfg(input logic [31:0] v);
    idle_in(); cfg_wr = 1; cfg_wdata = v; @(negedge clk); idle_in();
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    idle_in();
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1", "readback", cfg_rdata, 32'h0000_3000);
    chk("R1", "busy", {31'b0, busy}, 0);
    chk("R1", "irq", {31'b0, irq}, 0);
    chk("R1", "halt", {31'b0, halt}, 0);
    chk("R1", "run", {31'b0, xfer_run}, 0);
    chk("R1", "chain", {16'b0, chain_out}, 0);

    for (int k = 0; k < NV; k++) begin
      string tag;
      tag = $sformatf("R%0d row%0d", VT[k].rq, k);
      cfg_wr = VT[k].wr; cfg_wdata = VT[k].wd;
      trig_wr = VT[k].tw; trig_val = VT[k].tv;
      chain_in = VT[k].ci; xfer_done = VT[k].dn;
      rd_err = VT[k].re; wr_err = VT[k].we; abort = VT[k].ab;
      @(negedge clk);
      chk(tag, "busy", {31'b0, busy}, {31'b0, VT[k].eb});
      chk(tag, "irq", {31'b0, irq}, {31'b0, VT[k].ei});
      chk(tag, "chain", {16'b0, chain_out}, {16'b0, VT[k].ec});
      chk(tag, "halt", {31'b0, halt}, {31'b0, VT[k].eh});
    end
    idle_in();

    // R4 run indication across pause and resume
    cfg(32'h0000_1801);
    trig_wr = 1; trig_val = 32'h3; @(negedge clk); idle_in();
    chk("R4", "run active", {31'b0, xfer_run}, 1);
    chk("R11", "busy bit", {31'b0, cfg_rdata[24]}, 1);
    cfg(32'h0000_1800);
    chk("R4", "run paused", {31'b0, xfer_run}, 0);
    chk("R4", "busy paused", {31'b0, busy}, 1);
    cfg(32'h0000_1801);
    chk("R4", "run resumed", {31'b0, xfer_run}, 1);

    // R8 R7 write error readback and W1C rules
    wr_err = 1; @(negedge clk); idle_in();
    chk("R8", "err bits", {29'b0, cfg_rdata[31:29]}, 32'h5);
    chk("R11", "busy bit cleared", {31'b0, cfg_rdata[24]}, 0);
    cfg(32'h8000_1801);
    chk("R7", "bit31 write ignored", {29'b0, cfg_rdata[31:29]}, 32'h5);
    cfg(32'h2000_1801);
    chk("R7", "cleared", {29'b0, cfg_rdata[31:29]}, 0);
    chk("R11", "reserved zero", {28'b0, cfg_rdata[28:25]}, 0);

    // R1 reset from a modified state
    rst = 1; @(negedge clk); rst = 0;
    chk("R1", "readback after reset", cfg_rdata, 32'h0000_3000);

    finished = 1;
    summary();
    $finish;
  end
endmodule